// File: doc/BRIEF.md
# Parallel FPGA Configuration Streamer

This controller loads a slave FPGA over a byte-wide write port. A start pulse makes it reset the target with an active-low program pulse. It then waits for the target's active-low init line to go high, and a timeout bounds that wait. Once the target is ready, the controller writes a fixed header, followed by the payload in frames of 21 bytes. Each frame is wrapped in a preamble byte, a check byte and five padding bytes. Startup bytes close the stream.

The payload comes from a byte source with a valid/ready handshake. The source marks its final byte with a last flag. Each write is a single-cycle strobe. The data is held on the bus, and writes are spaced by a configurable number of idle cycles. When the run ends, the controller reports success or failure. Success means the whole payload went out and the target raised done after the startup bytes.

Top module: `fpga_cfg_streamer`

## Requirements
- R1: After reset: prog_n is high, cfg_we is low, and busy, ok, fail and tmo_err are all low.
- R2: A start pulse while idle drives prog_n low for exactly RESET_CYCLES clock cycles and then high. No byte is written while prog_n is low.
- R3: After prog_n is released, no byte is written while init_n is low. If init_n stays low for tmo_limit+1 cycles, the block sets tmo_err and fail, writes nothing and returns to idle.
- R4: The stream opens with the header bytes FF, FF, FF, 4F, 80, AF, 9B, 4B, in that order.
- R5: Each frame is written as 4F, then 21 payload bytes, then 4B, then FF, 4B, FF, FF, FF.
- R6: Payload bytes are taken only on cycles where src_valid and src_ready are both high, one byte per write and in source order. While src_valid is low the stream stalls.
- R7: Before each frame the block checks the target. If init_n is low or done is high, it stops streaming. When src_last accompanied the final (21st) byte of a frame, no further frame is sent. src_last on any other byte is ignored.
- R8: Every run that got past the init wait ends with exactly four FF startup bytes, whether it finished normally or stopped early.
- R9: At the end of a run, ok is high only if no early stop occurred and done is high GAP cycles after the last startup byte. Otherwise fail is high. ok and fail are never both high, both are low while busy, and both hold until the next start.
- R10: cfg_we is a one-cycle strobe. Consecutive writes are separated by at least GAP idle cycles, and header writes by exactly GAP idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a configuration run when idle |
| tmo_limit | input | TMO_W | Init-wait timeout, in cycles minus one |
| src_data | input | 8 | Payload byte from the source |
| src_valid | input | 1 | Source byte available |
| src_last | input | 1 | Marks the source's final byte |
| src_ready | output | 1 | Block accepts a payload byte this cycle |
| cfg_data | output | 8 | Byte on the target write port |
| cfg_we | output | 1 | One-cycle write strobe |
| prog_n | output | 1 | Active-low target program/reset |
| init_n | input | 1 | Active-low target not-ready; high means ready |
| done | input | 1 | Target configuration complete |
| busy | output | 1 | Run in progress |
| ok | output | 1 | Last run succeeded |
| fail | output | 1 | Last run failed |
| tmo_err | output | 1 | Last run timed out waiting for init |

## Verification
The bench measures the exact width of the program pulse. A design off by one cycle there would give a pulse one cycle too short or too long. The bench also holds init low both within and beyond the timeout. This exposes a design that writes too early or one that hangs.

It stops the target mid-stream by dropping init, and again by raising done, exactly at a frame boundary. A design that skips the boundary check, or drops the startup bytes, would produce a longer or shorter byte log and could report success wrongly. A stalling source checks that stalls neither duplicate nor skip payload bytes. Separate runs with and without done after startup separate the success and failure reports.

// File: rtl/fpga_cfg_streamer.sv
module fpga_cfg_streamer #(
  parameter int RESET_CYCLES = 50,
  parameter int GAP          = 2,
  parameter int TMO_W        = 24,
  parameter int FRAME_LEN    = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic [7:0]       src_data,
  input  logic             src_valid,
  input  logic             src_last,
  output logic             src_ready,
  output logic [7:0]       cfg_data,
  output logic             cfg_we,
  output logic             prog_n,
  input  logic             init_n,
  input  logic             done,
  output logic             busy,
  output logic             ok,
  output logic             fail,
  output logic             tmo_err
);

  localparam int RW = $clog2(RESET_CYCLES + 1);
  localparam int CW = (RW > TMO_W) ? RW : TMO_W;
  localparam int GW = $clog2(GAP + 2);
  localparam int IW = $clog2(FRAME_LEN + 8);

  localparam logic [7:0] B_PRE  = 8'h4F;
  localparam logic [7:0] B_CHK  = 8'h4B;
  localparam logic [7:0] B_FILL = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_WAIT, S_HDR, S_FCHK, S_PRE, S_PAY, S_CHK, S_PAD, S_STUP, S_FIN
  } state_t;

  state_t         st;
  logic [CW-1:0]  cnt;
  logic [GW-1:0]  gap;
  logic [IW-1:0]  idx;
  logic           early;
  logic           last_seen;

  wire go   = (gap == '0);
  wire take = src_ready && src_valid;

  assign src_ready = (st == S_PAY) && go;
  assign busy      = (st != S_IDLE);

  function automatic logic [7:0] hdr_byte(input logic [IW-1:0] i);
    case (i)
      IW'(3):  hdr_byte = B_PRE;
      IW'(4):  hdr_byte = 8'h80;
      IW'(5):  hdr_byte = 8'hAF;
      IW'(6):  hdr_byte = 8'h9B;
      IW'(7):  hdr_byte = B_CHK;
      default: hdr_byte = B_FILL;
    endcase
  endfunction

  function automatic logic [7:0] pad_byte(input logic [IW-1:0] i);
    pad_byte = (i == IW'(1)) ? B_CHK : B_FILL;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      gap       <= '0;
      idx       <= '0;
      early     <= 1'b0;
      last_seen <= 1'b0;
      cfg_data  <= 8'h00;
      cfg_we    <= 1'b0;
      prog_n    <= 1'b1;
      ok        <= 1'b0;
      fail      <= 1'b0;
      tmo_err   <= 1'b0;
    end else begin
      cfg_we <= 1'b0;
      if (!go) gap <= gap - 1'b1;
      case (st)
        S_IDLE:
          if (start) begin
            st        <= S_RST;
            cnt       <= CW'(RESET_CYCLES - 1);
            prog_n    <= 1'b0;
            ok        <= 1'b0;
            fail      <= 1'b0;
            tmo_err   <= 1'b0;
            early     <= 1'b0;
            last_seen <= 1'b0;
          end
        S_RST:
          if (cnt == '0) begin
            prog_n <= 1'b1;
            st     <= S_WAIT;
          end else begin
            cnt <= cnt - 1'b1;
          end
        S_WAIT:
          if (init_n) begin
            st  <= S_HDR;
            idx <= '0;
          end else if (cnt == CW'(tmo_limit)) begin
            tmo_err <= 1'b1;
            fail    <= 1'b1;
            st      <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_HDR:
          if (go) begin
            cfg_we   <= 1'b1;
            cfg_data <= hdr_byte(idx);
            gap      <= GW'(GAP);
            if (idx == IW'(7)) st <= S_FCHK;
            else idx <= idx + 1'b1;
          end
        S_FCHK: begin
          idx <= '0;
          if (last_seen) begin
            st <= S_STUP;
          end else if (!init_n || done) begin
            early <= 1'b1;
            st    <= S_STUP;
          end else begin
            st <= S_PRE;
          end
        end
        S_PRE:
          if (go) begin
            cfg_we   <= 1'b1;
            cfg_data <= B_PRE;
            gap      <= GW'(GAP);
            idx      <= '0;
            st       <= S_PAY;
          end
        S_PAY:
          if (take) begin
            cfg_we   <= 1'b1;
            cfg_data <= src_data;
            gap      <= GW'(GAP);
            if (idx == IW'(FRAME_LEN - 1)) begin
              last_seen <= src_last;
              st        <= S_CHK;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        S_CHK:
          if (go) begin
            cfg_we   <= 1'b1;
            cfg_data <= B_CHK;
            gap      <= GW'(GAP);
            idx      <= '0;
            st       <= S_PAD;
          end
        S_PAD:
          if (go) begin
            cfg_we   <= 1'b1;
            cfg_data <= pad_byte(idx);
            gap      <= GW'(GAP);
            if (idx == IW'(4)) st <= S_FCHK;
            else idx <= idx + 1'b1;
          end
        S_STUP:
          if (go) begin
            cfg_we   <= 1'b1;
            cfg_data <= B_FILL;
            gap      <= GW'(GAP);
            if (idx == IW'(3)) st <= S_FIN;
            else idx <= idx + 1'b1;
          end
        S_FIN:
          if (go) begin
            ok   <= !early && done;
            fail <= early || !done;
            st   <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (GAP > 0 && cfg_we) |=> !cfg_we);

  // R2
  prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> !cfg_we);

  // R6
  take_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready && src_valid) |=> (cfg_we && cfg_data == $past(src_data)));

  // R9
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && fail));

  // R9
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!ok && !fail));

  // R3
  tmo_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> (fail && !ok));

endmodule

// File: tb/test_fpga_cfg_streamer.sv
module test_fpga_cfg_streamer;
  localparam int RC  = 50;
  localparam int GP  = 2;
  localparam int TW  = 24;
  localparam int FL  = 21;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [TW-1:0] tmo_limit = 24'd1000;
  logic [7:0] src_data;
  logic src_valid, src_last, src_ready;
  logic [7:0] cfg_data;
  logic cfg_we, prog_n, busy, ok, fail, tmo_err;
  logic init_n = 1'b1, done = 1'b0;

  always #10 clk = ~clk;

  fpga_cfg_streamer #(.RESET_CYCLES(RC), .GAP(GP), .TMO_W(TW), .FRAME_LEN(FL)) i_fpga_cfg_streamer (
    .clk(clk), .rst_n(rst_n), .start(start), .tmo_limit(tmo_limit),
    .src_data(src_data), .src_valid(src_valid), .src_last(src_last), .src_ready(src_ready),
    .cfg_data(cfg_data), .cfg_we(cfg_we), .prog_n(prog_n), .init_n(init_n), .done(done),
    .busy(busy), .ok(ok), .fail(fail), .tmo_err(tmo_err));

  int nchk = 0, nerr = 0;
  logic [7:0] pay [0:127];
  int n_pay = 0, sidx = 0;
  logic stall_mode = 1'b0, tog = 1'b0;

  assign src_valid = (sidx < n_pay) && (!stall_mode || tog);
  assign src_data  = pay[sidx[6:0]];
  assign src_last  = (sidx == n_pay - 1);

  always @(posedge clk) begin
    tog <= ~tog;
    if (src_valid && src_ready) sidx <= sidx + 1;
  end

  logic [7:0] lg [0:255];
  int stamp [0:255];
  int nlog = 0, cyc = 0;
  int done_at = -1, stop_at = -1;
  logic stop_by_done = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cfg_we) begin
      lg[nlog[7:0]]    = cfg_data;
      stamp[nlog[7:0]] = cyc;
      nlog             = nlog + 1;
      if (nlog == done_at) done = 1'b1;
      if (nlog == stop_at) begin
        if (stop_by_done) done = 1'b1;
        else init_n = 1'b0;
      end
    end
  end

  logic [7:0] ex [0:255];
  int n_ex;

  task automatic check(input bit c, input string tag, input int act, input int exp);
    nchk++;
    if (!c) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic build(input int frames);
    logic [7:0] h [0:7];
    h = '{8'hFF, 8'hFF, 8'hFF, 8'h4F, 8'h80, 8'hAF, 8'h9B, 8'h4B};
    n_ex = 0;
    for (int i = 0; i < 8; i++) begin ex[n_ex] = h[i]; n_ex++; end
    for (int f = 0; f < frames; f++) begin
      ex[n_ex] = 8'h4F; n_ex++;
      for (int b = 0; b < FL; b++) begin ex[n_ex] = pay[f*FL+b]; n_ex++; end
      ex[n_ex] = 8'h4B; n_ex++;
      ex[n_ex] = 8'hFF; n_ex++;
      ex[n_ex] = 8'h4B; n_ex++;
      ex[n_ex] = 8'hFF; n_ex++;
      ex[n_ex] = 8'hFF; n_ex++;
      ex[n_ex] = 8'hFF; n_ex++;
    end
    for (int i = 0; i < 4; i++) begin ex[n_ex] = 8'hFF; n_ex++; end
  endtask

  task automatic cmp_seq(input string tag);
    int bad;
    bad = -1;
    check(nlog == n_ex, {tag, " length"}, nlog, n_ex);
    for (int i = 0; i < n_ex && i < nlog; i++)
      if (bad < 0 && lg[i] != ex[i]) bad = i;
    check(bad < 0, {tag, " byte"}, (bad < 0) ? 0 : lg[bad], (bad < 0) ? 0 : ex[bad]);
  endtask

  task automatic prep(input int frames, input int seed);
    @(negedge clk);
    n_pay = frames * FL;
    for (int i = 0; i < n_pay; i++) pay[i] = 8'((i * 37 + seed) & 255);
    sidx = 0; nlog = 0; done = 1'b0; done_at = -1; stop_at = -1;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(prog_n == 1'b1 && cfg_we == 1'b0, "R1 prog_n/cfg_we", {prog_n, cfg_we}, 2);
    check({busy, ok, fail, tmo_err} == 4'b0, "R1 status", {busy, ok, fail, tmo_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_pulse_and_one_frame();
    int low;
    prep(1, 5);
    init_n = 1'b0;
    done_at = 8 + 28 + 4;
    pulse_start();
    low = 0;
    for (int i = 0; i < 200 && prog_n == 1'b0; i++) begin low++; @(negedge clk); end
    // R2
    check(low == RC, "R2 program pulse width", low, RC);
    repeat (30) @(negedge clk);
    // R3
    check(nlog == 0, "R3 no write while init low", nlog, 0);
    init_n = 1'b1;
    wait_idle();
    build(1);
    cmp_seq("R4 R5 R8 one frame");
    // R9
    check(ok == 1'b1 && fail == 1'b0, "R9 success", {ok, fail}, 2);
    // R10
    check(stamp[1] - stamp[0] == GP + 1, "R10 header spacing", stamp[1] - stamp[0], GP + 1);
  endtask

  task automatic t_timeout();
    prep(1, 9);
    tmo_limit = 24'd20;
    init_n = 1'b0;
    pulse_start();
    wait_idle();
    // R3
    check(tmo_err == 1'b1 && fail == 1'b1 && ok == 1'b0, "R3 timeout flags", {tmo_err, fail, ok}, 6);
    check(nlog == 0, "R3 nothing written on timeout", nlog, 0);
    check(busy == 1'b0, "R3 back to idle", busy, 0);
    init_n = 1'b1;
    tmo_limit = 24'd1000;
  endtask

  task automatic t_two_frames_stall();
    int mingap;
    prep(2, 77);
    stall_mode = 1'b1;
    done_at = 8 + 56 + 4;
    pulse_start();
    wait_idle();
    stall_mode = 1'b0;
    build(2);
    cmp_seq("R5 R6 two frames with stalls");
    // R6
    check(sidx == 2 * FL, "R6 bytes consumed", sidx, 2 * FL);
    check(ok == 1'b1, "R9 two frames ok", ok, 1);
    mingap = 1000;
    for (int i = 1; i < nlog; i++) if (stamp[i] - stamp[i-1] < mingap) mingap = stamp[i] - stamp[i-1];
    // R10
    check(mingap >= GP + 1, "R10 min spacing", mingap, GP + 1);
  endtask

  task automatic t_no_done();
    prep(1, 3);
    pulse_start();
    wait_idle();
    build(1);
    cmp_seq("R8 startup without done");
    // R9
    check(ok == 1'b0 && fail == 1'b1, "R9 fail when done low", {ok, fail}, 1);
  endtask

  task automatic t_stop(input logic by_done, input string tag);
    prep(3, 11);
    stop_by_done = by_done;
    stop_at = 8 + 28;
    pulse_start();
    wait_idle();
    build(1);
    cmp_seq({"R7 R8 ", tag});
    // R7
    check(sidx == FL, {"R7 payload left ", tag}, sidx, FL);
    // R9
    check(ok == 1'b0 && fail == 1'b1, {"R9 early stop fails ", tag}, {ok, fail}, 1);
    init_n = 1'b1; done = 1'b0;
  endtask

  initial begin
    t_reset();
    t_pulse_and_one_frame();
    t_timeout();
    t_two_frames_stall();
    t_no_done();
    t_stop(1'b0, "init drop");
    t_stop(1'b1, "done rise");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule